// File: doc/BRIEF.md
# RTC interrupt flag and status registers

This block holds the interrupt-status part of a real-time clock register file. Three event sources feed it: a tap of the clock's divider chain, a pulse when the alarm matches and a pulse when a time update completes. Each source sets its own sticky flag. A flag is set whatever the state of its enable. Three enable bits come in as plain inputs. Each enable gates its flag into a summary interrupt bit, and that bit drives an active-low interrupt pin.

The bus side has a single read port with a register select. The flag register returns the summary bit and the three flags. A read of the flag register clears all three flags on the clock edge that ends the read, and the data returned is the value from before the clear. The status register returns a battery-valid bit, which follows an input directly and does not depend on reset. Bits with no function read zero in both registers. No write path exists.

Top module: `rtc_irq_status`

## Requirements
- R1: In the flag register, bit 7 is the summary bit, bit 6 the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3..0 always read 0. The flag register is selected with `rd_sel_i` = 0.
- R2: The summary bit equals (periodic AND `per_en_i`) OR (alarm AND `alm_en_i`) OR (update AND `upd_en_i`), and follows enable changes in the same cycle.
- R3: A rising edge on `tap_i` sets the periodic flag on that clock edge, whatever `per_en_i` is. The edge is `tap_i` = 1 where the value sampled on the previous clock was 0. A tap held high does not count as a new edge.
- R4: A pulse on `alarm_hit_i` sets the alarm flag and a pulse on `update_done_i` sets the update flag, whatever their enables are.
- R5: A cycle with `rd_i` = 1 and `rd_sel_i` = 0 returns the flags as they stood before the read. The read then clears all three flags at the clock edge.
- R6: A set event in the same cycle as a clearing read leaves its flag set after the read.
- R7: A read with `rd_sel_i` = 1 leaves every flag unchanged.
- R8: `irq_no` is 0 exactly when the summary bit is 1.
- R9: The status register (`rd_sel_i` = 1) returns `batt_ok_i` in bit 7 and 0 in bits 6..0. Reset has no effect on it.
- R10: While `rst_ni` is 0, all three flags are 0 and the tap history is 0. A tap that is high at the first clock after reset therefore counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tap_i | input | 1 | Selected divider tap level |
| alarm_hit_i | input | 1 | Alarm-match pulse |
| update_done_i | input | 1 | Update-ended pulse |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| upd_en_i | input | 1 | Update interrupt enable |
| batt_ok_i | input | 1 | Backup supply good |
| rd_i | input | 1 | One-cycle read strobe |
| rd_sel_i | input | 1 | 0 = flag register, 1 = status register |
| rd_data_o | output | 8 | Read data for the selected register |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with the default rising-edge tap detection. That default makes the R3 and R10 cases reachable: a held-high tap must not set the flag again, and a tap that is high right out of reset must set it. The behavioural model updates the flags on each clock from the same inputs. It compares both registers and the interrupt pin in every cycle, both in directed sequences and under random event, enable and read traffic. That traffic includes reads that coincide with set events.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned N_EVT = 3;
  // flag vector index; flag i sits at register bit FLAG_LSB + i
  localparam int unsigned EVT_UPD  = 0;
  localparam int unsigned EVT_ALM  = 1;
  localparam int unsigned EVT_PER  = 2;
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned SUM_BIT  = FLAG_LSB + N_EVT;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_STATUS = 1'b1
  } rd_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_mode_e;
endpackage

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge
  import rtc_irq_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tap_i,
  output logic edge_o
);
  logic tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap_i;
  end

  generate
    if (MODE == EDGE_FALL) begin : g_fall
      assign edge_o = ~tap_i & tap_q;
    end else if (MODE == EDGE_BOTH) begin : g_both
      assign edge_o = tap_i ^ tap_q;
    end else begin : g_rise
      assign edge_o = tap_i & ~tap_q;
    end
  endgenerate
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;

    // a set in the clearing cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end

    assign flags_o[i] = flag_q;

    a_r4_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]);
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[i]) |=> !flags_o[i]);
    a_r7_hold_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !clr_i) |=> flags_o[i]);
  end
endmodule

// File: rtl/rtc_reg_read.sv
module rtc_reg_read
  import rtc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] flags_i,
  input  logic [N_EVT-1:0] en_i,
  input  logic             batt_ok_i,
  input  rd_sel_e          sel_i,
  output logic             summary_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [REG_W-1:0] flag_reg, stat_reg;

  assign summary_o = |(flags_i & en_i);

  always_comb begin
    flag_reg = '0;
    flag_reg[SUM_BIT] = summary_o;
    flag_reg[FLAG_LSB +: N_EVT] = flags_i;
    stat_reg = '0;
    stat_reg[REG_W-1] = batt_ok_i;
  end

  assign rd_data_o = (sel_i == SEL_STATUS) ? stat_reg : flag_reg;

  a_r1_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_FLAGS) |-> (rd_data_o[FLAG_LSB-1:0] == '0));
  a_r9_status_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_STATUS) |-> (rd_data_o[REG_W-2:0] == '0));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
#(
  parameter edge_mode_e TAP_EDGE = EDGE_RISE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tap_i,
  input  logic       alarm_hit_i,
  input  logic       update_done_i,
  input  logic       per_en_i,
  input  logic       alm_en_i,
  input  logic       upd_en_i,
  input  logic       batt_ok_i,
  input  logic       rd_i,
  input  logic       rd_sel_i,
  output logic [7:0] rd_data_o,
  output logic       irq_no
);
  logic             per_edge, clr, summary;
  logic [N_EVT-1:0] set_vec, en_vec, flags;
  rd_sel_e          sel;

  assign sel = rd_sel_e'(rd_sel_i);
  assign clr = rd_i & (sel == SEL_FLAGS);

  always_comb begin
    set_vec = '0;
    set_vec[EVT_PER] = per_edge;
    set_vec[EVT_ALM] = alarm_hit_i;
    set_vec[EVT_UPD] = update_done_i;
    en_vec = '0;
    en_vec[EVT_PER] = per_en_i;
    en_vec[EVT_ALM] = alm_en_i;
    en_vec[EVT_UPD] = upd_en_i;
  end

  rtc_tap_edge #(.MODE(TAP_EDGE)) i_tap_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_i  (tap_i),
    .edge_o (per_edge)
  );

  rtc_flag_bank #(.N(N_EVT)) i_flag_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr),
    .flags_o (flags)
  );

  rtc_reg_read i_reg_read (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flags_i   (flags),
    .en_i      (en_vec),
    .batt_ok_i (batt_ok_i),
    .sel_i     (sel),
    .summary_o (summary),
    .rd_data_o (rd_data_o)
  );

  assign irq_no = ~summary;

  a_r2_enabled_flag_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags & en_vec) != '0) |-> !irq_no);
  a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags & en_vec) == '0) |-> irq_no);
  a_r6_set_beats_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && alarm_hit_i) |=> flags[EVT_ALM]);
endmodule

// File: tb/test_rtc_irq_status.sv
`timescale 1ns/1ps
module test_rtc_irq_status;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tap = 0, alm = 0, upd = 0, pe = 0, ae = 0, ue = 0, bat = 1, rd = 0, sel = 0;
  logic [7:0] rd_data;
  logic irq_no;
  int total = 0, bad = 0;
  bit done = 0;
  bit m_pf, m_af, m_uf, m_tap;

  always #2 clk = ~clk;

  rtc_irq_status i_rtc_irq_status (
    .clk_i(clk), .rst_ni(rst_ni), .tap_i(tap), .alarm_hit_i(alm),
    .update_done_i(upd), .per_en_i(pe), .alm_en_i(ae), .upd_en_i(ue),
    .batt_ok_i(bat), .rd_i(rd), .rd_sel_i(sel), .rd_data_o(rd_data), .irq_no(irq_no)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_data();
    bit s;
    s = (m_pf & pe) | (m_af & ae) | (m_uf & ue);
    if (sel) return {bat, 7'b0};
    return {s, m_pf, m_af, m_uf, 4'b0};
  endfunction

  function automatic bit exp_irq_n();
    return !((m_pf & pe) | (m_af & ae) | (m_uf & ue));
  endfunction

  // called at negedge: drive, check combinational view, advance model at posedge
  task automatic step(string tag, bit t, bit a, bit u, bit p_e, bit a_e, bit u_e,
                      bit b, bit r, bit s);
    bit edge_hit, clr;
    tap = t; alm = a; upd = u; pe = p_e; ae = a_e; ue = u_e; bat = b; rd = r; sel = s;
    #1;
    chk(tag, rd_data, exp_data());
    chk("R8", {7'b0, irq_no}, {7'b0, exp_irq_n()});
    @(posedge clk);
    edge_hit = t & ~m_tap;
    m_tap = t;
    clr = r & ~s;
    m_pf = edge_hit | (m_pf & ~clr);
    m_af = a | (m_af & ~clr);
    m_uf = u | (m_uf & ~clr);
    @(negedge clk);
  endtask

  task automatic do_reset(bit t);
    rst_ni = 1'b0; tap = t; rd = 0; sel = 0;
    m_pf = 0; m_af = 0; m_uf = 0; m_tap = 0;
    #1;
    chk("R10", rd_data, 8'h00);
    chk("R10", {7'b0, irq_no}, 8'h01);
    sel = 1; bat = 0; #1;
    chk("R9", rd_data, 8'h00);
    bat = 1; #1;
    chk("R9", rd_data, 8'h80);
    sel = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(0);
    // R3: rising edge sets periodic flag with enable off; held-high tap no re-edge
    step("R3", 0,0,0, 0,0,0, 1, 0,0);
    step("R3", 1,0,0, 0,0,0, 1, 0,0);
    step("R3", 1,0,0, 0,0,0, 1, 0,0);
    step("R5", 1,0,0, 0,0,0, 1, 1,0);
    step("R3", 1,0,0, 0,0,0, 1, 0,0);
    step("R3", 0,0,0, 0,0,0, 1, 0,0);
    // R4: alarm and update set without enables
    step("R4", 0,1,0, 0,0,0, 1, 0,0);
    step("R4", 0,0,1, 0,0,0, 1, 0,0);
    step("R4", 0,0,0, 0,0,0, 1, 0,0);
    // R2: enables one at a time
    step("R2", 0,0,0, 1,0,0, 1, 0,0);
    step("R2", 0,0,0, 0,1,0, 1, 0,0);
    step("R2", 0,0,0, 0,0,1, 1, 0,0);
    step("R2", 1,0,0, 1,1,1, 1, 0,0);
    // R7: status read leaves flags
    step("R7", 0,0,0, 1,1,1, 1, 1,1);
    step("R7", 0,0,0, 1,1,1, 0, 0,1);
    step("R7", 0,0,0, 1,1,1, 1, 0,0);
    // R5: flag read returns old value and clears
    step("R5", 0,0,0, 1,1,1, 1, 1,0);
    step("R5", 0,0,0, 1,1,1, 1, 0,0);
    // R6: set during clearing read survives
    step("R6", 0,0,1, 0,0,0, 1, 0,0);
    step("R6", 1,1,0, 0,0,0, 1, 1,0);
    step("R6", 0,0,0, 1,1,1, 1, 0,0);
    // R9: battery bit
    step("R9", 0,0,0, 0,0,0, 0, 0,1);
    step("R9", 0,0,0, 0,0,0, 1, 0,1);
    // R10: reset mid-run, tap high straight out of reset counts as edge
    step("R10", 0,1,1, 1,1,1, 1, 0,0);
    do_reset(1);
    step("R10", 1,0,0, 1,0,0, 1, 0,0);
    step("R10", 1,0,0, 1,0,0, 1, 0,0);
    // R1: random traffic
    for (int i = 0; i < 600; i++) begin
      logic [9:0] v;
      v = 10'($urandom);
      step(v[9] ? "R9" : "R1", v[0], v[1] & v[2], v[3] & v[4], v[5], v[6], v[7],
           (i % 50) != 7, v[8] & v[2], v[9] & v[4]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule